// File: doc/BRIEF.md
# Codec power sequencing controller

This block steps a converter device through power-up and power-down. It runs on the master clock. After the active-low reset is released, it waits a programmed interval, made of whole milliseconds plus a fixed number of extra cycles. Then it captures the bus address straps and opens the control port. Until that moment, control-port requests get no acknowledge.

A frame-rate meter counts master-clock cycles between rising edges of the frame clock. It classifies the ratio as 256, 384 or 512 within a small tolerance. A count outside every class, or a frame clock that stops, raises a sticky clock-error flag. The analog output clamps open and the references come up only when the ratio is valid and at least one converter power-down bit is clear.

For shutdown, the ramp request holds the outputs clamped while a millisecond timer measures the discharge interval. The block then reports that reset or clock removal is safe. A low reset at any time drops the block back to its boot state.

Top module: `codec_pwr_seq`

## Requirements
- R1: While rst_ni is low: port_ready_o=0, cp_ack_o=0, clamp_o=1, refs_up_o=0, ramp_done_o=0, clk_valid_o=0, clk_err_o=0 and ratio_o=0.
- R2: port_ready_o rises on exactly the master-clock edge number ADDR_MS*CLKS_PER_MS+ADDR_EXTRA after rst_ni rises. On that edge addr_o captures addr_pins_i, and addr_o then holds that value whatever the pins do.
- R3: cp_ack_o is high only when cp_req_i is high and the port is ready. A request before the address is captured gets no acknowledge.
- R4: The cycle count between two successive frame-clock rising edges sets ratio_o: 1 for 256, 2 for 384, 3 for 512. A count within ±RATIO_TOL of one of these values is accepted, and clk_valid_o is then high.
- R5: A count outside every tolerance window, or more than 1024 cycles with no rising edge once frames have been seen, sets clk_err_o. It also drops clk_valid_o and sets ratio_o to 0. clk_err_o stays set until reset.
- R6: Once the port is ready, clamp_o falls and refs_up_o rises on the first edge where clk_valid_o is high and at least one bit of pdn_i is 0. The clamp returns when all pdn_i bits are 1 or the clock becomes invalid.
- R7: ramp_req_i high after boot holds clamp_o=1. ramp_done_o rises exactly RAMP_MS*CLKS_PER_MS cycles after the edge that accepts the request. Dropping ramp_req_i clears ramp_done_o.
- R8: pll_en_o is 1 for rate codes 0 and 1, and 0 for every other code.
- R9: Pulling rst_ni low at any time immediately re-clamps the outputs and closes the control port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_i | input | 1 | Frame clock (asynchronous, synchronized inside) |
| addr_pins_i | input | ADDR_W | Bus address straps |
| pdn_i | input | N_CONV | Converter power-down bits, 1 = powered down |
| ramp_req_i | input | 1 | Shutdown ramp request |
| rate_code_i | input | RATE_W | Master-clock rate code |
| cp_req_i | input | 1 | Control-port access request |
| port_ready_o | output | 1 | Address captured, control port open |
| addr_o | output | ADDR_W | Captured address |
| cp_ack_o | output | 1 | Control-port access accepted |
| ratio_o | output | 2 | Detected ratio class (0 none, 1/2/3 = 256/384/512) |
| clk_valid_o | output | 1 | Last frame period fell in a tolerance window |
| clk_err_o | output | 1 | Sticky clock-error interrupt flag |
| pll_en_o | output | 1 | PLL enable decoded from rate code |
| clamp_o | output | 1 | Outputs clamped to quiescent level |
| refs_up_o | output | 1 | References powered |
| ramp_done_o | output | 1 | Ramp interval elapsed |

## Verification
The hardest cases are the exact edges of the two timers and a lost frame clock during normal operation. The bench releases reset on a falling clock edge and counts rising edges from there. It samples the port one edge before and one edge after the computed boot and ramp instants. A frame generator only changes its period at frame boundaries, so every measured period is whole. Setting that period to zero while unclamped makes the meter's timeout the only way the clamp can return.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_RAMP = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RAT_NONE = 2'd0,
    RAT_256  = 2'd1,
    RAT_384  = 2'd2,
    RAT_512  = 2'd3
  } ratio_e;

  localparam int unsigned N_RATIOS = 3;
  localparam int unsigned RATIO_NOM [N_RATIOS] = '{256, 384, 512};
  localparam int unsigned LOST_LIM = 1024;
endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
  parameter int unsigned CLKS_PER_MS = 25600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (CLKS_PER_MS > 2) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R7
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
endmodule

// File: rtl/frame_ratio_meter.sv
module frame_ratio_meter
  import pwr_seq_pkg::*;
#(
  parameter int unsigned RATIO_TOL = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fs_i,
  output logic [1:0] ratio_o,
  output logic       valid_o,
  output logic       err_o
);
  localparam int unsigned CW = $clog2(LOST_LIM + 1);
  localparam logic [CW-1:0] LOST = CW'(LOST_LIM);

  logic [2:0]          fs_sync_q;
  logic                rise;
  logic [CW-1:0]       cnt_q;
  logic                seen_q;
  logic [N_RATIOS-1:0] hit;
  ratio_e              cls;
  ratio_e              ratio_q;
  logic                valid_q;
  logic                err_q;

  assign rise = fs_sync_q[1] & ~fs_sync_q[2];

  for (genvar i = 0; i < N_RATIOS; i++) begin : g_win
    assign hit[i] = (cnt_q >= CW'(RATIO_NOM[i] - RATIO_TOL)) &&
                    (cnt_q <= CW'(RATIO_NOM[i] + RATIO_TOL));
  end

  always_comb begin
    if      (hit[0]) cls = RAT_256;
    else if (hit[1]) cls = RAT_384;
    else if (hit[2]) cls = RAT_512;
    else             cls = RAT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_sync_q <= '0;
      cnt_q     <= '0;
      seen_q    <= 1'b0;
      ratio_q   <= RAT_NONE;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      fs_sync_q <= {fs_sync_q[1:0], fs_i};
      if (rise) begin
        cnt_q  <= CW'(1);
        seen_q <= 1'b1;
        if (seen_q) begin
          ratio_q <= cls;
          valid_q <= (cls != RAT_NONE);
          if (cls == RAT_NONE) err_q <= 1'b1;
        end
      end else if (seen_q && cnt_q == LOST) begin
        // frame clock stopped
        seen_q  <= 1'b0;
        ratio_q <= RAT_NONE;
        valid_q <= 1'b0;
        err_q   <= 1'b1;
      end else if (cnt_q != LOST) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ratio_o = ratio_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R4
  valid_needs_frames_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> seen_q);
  // R5
  err_drops_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> !valid_q);
  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q) |-> err_q);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned N_CONV     = 9,
  parameter int unsigned ADDR_MS    = 2,
  parameter int unsigned ADDR_EXTRA = 3000,
  parameter int unsigned RAMP_MS    = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clk_valid_i,
  input  logic [N_CONV-1:0] pdn_i,
  input  logic              ramp_req_i,
  input  logic [ADDR_W-1:0] addr_pins_i,
  output logic              pre_clr_o,
  output logic              port_ready_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              clamp_o,
  output logic              refs_up_o,
  output logic              ramp_done_o
);
  localparam int unsigned MS_MAX = (ADDR_MS > RAMP_MS) ? ADDR_MS : RAMP_MS;
  localparam int unsigned MW = $clog2(MS_MAX + 1);
  localparam int unsigned EW = $clog2(ADDR_EXTRA + 1);

  seq_state_e        st_q, st_d;
  logic [MW-1:0]     ms_q;
  logic [EW-1:0]     ex_q;
  logic [ADDR_W-1:0] addr_q;
  logic              boot_ms_done;
  logic              any_on;

  assign boot_ms_done = (ms_q == MW'(ADDR_MS));
  assign any_on       = ~&pdn_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_BOOT: if (boot_ms_done && ex_q == EW'(ADDR_EXTRA - 1)) st_d = ST_WAIT;
      ST_WAIT: begin
        if (ramp_req_i)                  st_d = ST_RAMP;
        else if (clk_valid_i && any_on)  st_d = ST_RUN;
      end
      ST_RUN: begin
        if (ramp_req_i)                    st_d = ST_RAMP;
        else if (!clk_valid_i || !any_on)  st_d = ST_WAIT;
      end
      ST_RAMP: if (!ramp_req_i) st_d = ST_WAIT;
      default: st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_BOOT;
      ms_q   <= '0;
      ex_q   <= '0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) begin
        ms_q <= '0;
        ex_q <= '0;
      end else if (st_q == ST_BOOT) begin
        if (!boot_ms_done) begin
          if (tick_i) ms_q <= ms_q + 1'b1;
        end else begin
          ex_q <= ex_q + 1'b1;
        end
      end else if (st_q == ST_RAMP) begin
        if (tick_i && ms_q != MW'(RAMP_MS)) ms_q <= ms_q + 1'b1;
      end
      if (st_q == ST_BOOT && st_d == ST_WAIT) addr_q <= addr_pins_i;
    end
  end

  assign pre_clr_o    = !(st_q == ST_BOOT || st_q == ST_RAMP);
  assign port_ready_o = (st_q != ST_BOOT);
  assign addr_o       = addr_q;
  assign clamp_o      = (st_q != ST_RUN);
  assign refs_up_o    = (st_q == ST_RUN);
  assign ramp_done_o  = (st_q == ST_RAMP) && (ms_q == MW'(RAMP_MS));

  // R6
  run_needs_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> $past(clk_valid_i));
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_ready_o && $past(port_ready_o)) |-> $stable(addr_q));
  // R7
  done_from_ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_done_o) |-> $past(st_q == ST_RAMP));
  // R2
  boot_ms_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BOOT) |-> (ms_q <= MW'(ADDR_MS)));
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLKS_PER_MS = 25600,
  parameter int unsigned ADDR_MS     = 2,
  parameter int unsigned ADDR_EXTRA  = 3000,
  parameter int unsigned RAMP_MS     = 50,
  parameter int unsigned RATIO_TOL   = 2,
  parameter int unsigned N_CONV      = 9,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned RATE_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic [ADDR_W-1:0] addr_pins_i,
  input  logic [N_CONV-1:0] pdn_i,
  input  logic              ramp_req_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic              cp_req_i,
  output logic              port_ready_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cp_ack_o,
  output logic [1:0]        ratio_o,
  output logic              clk_valid_o,
  output logic              clk_err_o,
  output logic              pll_en_o,
  output logic              clamp_o,
  output logic              refs_up_o,
  output logic              ramp_done_o
);
  logic tick;
  logic pre_clr;

  ms_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_clr),
    .tick_o (tick)
  );

  frame_ratio_meter #(.RATIO_TOL(RATIO_TOL)) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fs_i    (fs_i),
    .ratio_o (ratio_o),
    .valid_o (clk_valid_o),
    .err_o   (clk_err_o)
  );

  seq_fsm #(
    .ADDR_W     (ADDR_W),
    .N_CONV     (N_CONV),
    .ADDR_MS    (ADDR_MS),
    .ADDR_EXTRA (ADDR_EXTRA),
    .RAMP_MS    (RAMP_MS)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .clk_valid_i  (clk_valid_o),
    .pdn_i        (pdn_i),
    .ramp_req_i   (ramp_req_i),
    .addr_pins_i  (addr_pins_i),
    .pre_clr_o    (pre_clr),
    .port_ready_o (port_ready_o),
    .addr_o       (addr_o),
    .clamp_o      (clamp_o),
    .refs_up_o    (refs_up_o),
    .ramp_done_o  (ramp_done_o)
  );

  assign cp_ack_o = cp_req_i & port_ready_o;
  assign pll_en_o = (rate_code_i[RATE_W-1:1] == '0);

  // R3
  no_early_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_ack_o |-> port_ready_o);
  // R6
  clamp_refs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clamp_o && refs_up_o));
endmodule

// File: tb/sim_codec_pwr_seq.sv
module sim_codec_pwr_seq;
  localparam int CPM   = 20;
  localparam int AMS   = 2;
  localparam int AEX   = 30;
  localparam int RMS   = 50;
  localparam int BOOT  = AMS * CPM + AEX;
  localparam int RAMPC = RMS * CPM;
  localparam int NC    = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs = 1'b0;
  logic [2:0]    addr_pins = 3'b000;
  logic [NC-1:0] pdn = '1;
  logic          ramp_req = 1'b0;
  logic [2:0]    rate_code = 3'd0;
  logic          cp_req = 1'b0;
  logic          port_ready, cp_ack, clk_valid, clk_err, pll_en, clamp, refs_up, ramp_done;
  logic [2:0]    addr_o;
  logic [1:0]    ratio;

  int checks = 0;
  int errors = 0;
  int fs_period = 0;

  always #10 clk = ~clk;

  codec_pwr_seq #(
    .CLKS_PER_MS(CPM), .ADDR_MS(AMS), .ADDR_EXTRA(AEX), .RAMP_MS(RMS),
    .RATIO_TOL(2), .N_CONV(NC), .ADDR_W(3), .RATE_W(3)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fs_i(fs), .addr_pins_i(addr_pins), .pdn_i(pdn),
    .ramp_req_i(ramp_req), .rate_code_i(rate_code), .cp_req_i(cp_req),
    .port_ready_o(port_ready), .addr_o(addr_o), .cp_ack_o(cp_ack), .ratio_o(ratio),
    .clk_valid_o(clk_valid), .clk_err_o(clk_err), .pll_en_o(pll_en), .clamp_o(clamp),
    .refs_up_o(refs_up), .ramp_done_o(ramp_done)
  );

  // frame clock generator; period taken at each frame start
  initial begin
    forever begin
      if (fs_period == 0) begin
        fs = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = fs_period;
        fs = 1'b1;
        repeat (p / 2) @(negedge clk);
        fs = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic boot(input logic [2:0] pins);
    rst_n = 1'b0;
    addr_pins = pins;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (BOOT + 2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    cp_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 port_ready", port_ready, 0);
    chk("R1 cp_ack", cp_ack, 0);
    chk("R1 clamp", clamp, 1);
    chk("R1 refs_up", refs_up, 0);
    chk("R1 ramp_done", ramp_done, 0);
    chk("R1 clk_valid", clk_valid, 0);
    chk("R1 clk_err", clk_err, 0);
    chk("R1 ratio", ratio, 0);
  endtask

  task automatic t_addr_latch();
    addr_pins = 3'b101;
    cp_req = 1'b1;
    rst_n = 1'b1;
    repeat (BOOT - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 ready before delay", port_ready, 0);
    chk("R3 ack before ready", cp_ack, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 ready at delay", port_ready, 1);
    chk("R2 addr captured", addr_o, 5);
    chk("R3 ack after ready", cp_ack, 1);
    addr_pins = 3'b010;
    repeat (5) @(negedge clk);
    chk("R2 addr held", addr_o, 5);
    cp_req = 1'b0;
    @(negedge clk);
    chk("R3 no ack without req", cp_ack, 0);
  endtask

  task automatic t_ratio_unclamp();
    fs_period = 384;
    pdn = '1;
    repeat (4 * 384) @(negedge clk);
    chk("R4 ratio 384", ratio, 2);
    chk("R4 valid 384", clk_valid, 1);
    chk("R6 clamped all pdn", clamp, 1);
    pdn[1] = 1'b0;
    @(negedge clk);
    chk("R6 unclamp", clamp, 0);
    chk("R6 refs up", refs_up, 1);
    pdn = '1;
    @(negedge clk);
    chk("R6 reclamp on pdn", clamp, 1);
    chk("R6 refs down", refs_up, 0);
  endtask

  task automatic t_other_ratios();
    fs_period = 258;
    repeat (4 * 384) @(negedge clk);
    chk("R4 ratio 258 as 256", ratio, 1);
    fs_period = 254;
    repeat (4 * 258) @(negedge clk);
    chk("R4 ratio 254 as 256", ratio, 1);
    fs_period = 514;
    repeat (4 * 514) @(negedge clk);
    chk("R4 ratio 514 as 512", ratio, 3);
    chk("R4 valid 512", clk_valid, 1);
    chk("R5 no error in window", clk_err, 0);
  endtask

  task automatic t_bad_ratio();
    boot(3'b000);
    fs_period = 259;
    pdn = '0;
    repeat (5 * 259) @(negedge clk);
    chk("R5 err on 259", clk_err, 1);
    chk("R5 valid low", clk_valid, 0);
    chk("R5 ratio none", ratio, 0);
    chk("R6 stays clamped", clamp, 1);
    fs_period = 256;
    repeat (4 * 259) @(negedge clk);
    chk("R5 err sticky", clk_err, 1);
    chk("R6 unclamp after recovery", clamp, 0);
  endtask

  task automatic t_clock_loss();
    boot(3'b000);
    fs_period = 512;
    pdn = 9'b1_1111_1110;
    repeat (4 * 512) @(negedge clk);
    chk("R6 running", clamp, 0);
    chk("R5 no err yet", clk_err, 0);
    fs_period = 0;
    repeat (512 + 1100) @(negedge clk);
    chk("R5 err on loss", clk_err, 1);
    chk("R5 valid lost", clk_valid, 0);
    chk("R6 reclamp on loss", clamp, 1);
  endtask

  task automatic t_ramp();
    boot(3'b000);
    fs_period = 256;
    pdn = 9'b0_0000_0001;
    repeat (4 * 256) @(negedge clk);
    chk("R6 running before ramp", clamp, 0);
    pdn = '1;
    ramp_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 clamp in ramp", clamp, 1);
    repeat (RAMPC - 1) @(posedge clk);
    @(negedge clk);
    chk("R7 not done early", ramp_done, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 done at interval", ramp_done, 1);
    chk("R7 still clamped", clamp, 1);
    ramp_req = 1'b0;
    @(negedge clk);
    chk("R7 done cleared", ramp_done, 0);
  endtask

  task automatic t_async_reset();
    pdn = 9'b1_0000_0000;
    repeat (600) @(negedge clk);
    chk("R9 running before reset", clamp, 0);
    #3 rst_n = 1'b0;
    #1;
    chk("R9 clamp on reset", clamp, 1);
    chk("R9 port closed", port_ready, 0);
    chk("R9 refs down", refs_up, 0);
  endtask

  task automatic t_pll();
    for (int c = 0; c < 8; c++) begin
      rate_code = 3'(c);
      #1;
      chk("R8 pll enable", pll_en, (c < 2) ? 1 : 0);
    end
  endtask

  initial begin
    t_reset_state();
    @(negedge clk);
    t_addr_latch();
    t_ratio_unclamp();
    t_other_ratios();
    t_bad_ratio();
    t_clock_loss();
    t_ramp();
    t_async_reset();
    t_pll();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule